// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block is a purely combinational 32-bit binary adder. It takes two operands and a carry-in and produces the 32-bit sum and the carry out of the most significant bit. The operand width is split into four 8-bit slices. Inside a slice, every bit's carry comes straight from the per-bit generate and propagate terms and the slice's carry-in, so no carry passes from bit to bit inside a slice.

Between slices the carry does ripple. Each slice's carry-out drives the carry-in of the next more significant slice. The worst-case path is therefore one lookahead expansion per slice, four slices long, instead of thirty-two single-bit carry stages.

Integrators use it wherever a medium-latency wide add or subtract is needed. For a subtract, the caller supplies the inverted subtrahend and a carry-in of 1.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low 32 bits of the unsigned value `a + b + cin`, for every input combination, including all-zero inputs, which give a sum of 0.
- R2: `cout` equals bit 32 of the 33-bit unsigned value `a + b + cin`.
- R3: The carry entering slice k (bits 8k up to 8k+7, k = 1..3) equals bit 8k of the unsigned sum of the low 8k bits of both operands plus `cin`. At the ports, a run of ones in the low slice with `cin` = 1 therefore sets bit 8 of `sum`.
- R4: `a` = `b` = 32'h0000_0000 with `cin` = 1 gives `sum` = 32'h0000_0001 and `cout` = 0. The external carry-in enters bit 0.
- R5: `a` = 32'hFFFF_FFFF, `b` = 0 and `cin` = 1 gives `sum` = 0 and `cout` = 1. The carry crosses every slice boundary.
- R6: When `b` is the bitwise inverse of `a`, `sum` is 32'hFFFF_FFFF with `cout` = 0 if `cin` = 0, and 0 with `cout` = 1 if `cin` = 1.
- R7: Exchanging `a` and `b` leaves `sum` and `cout` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | 32    | First operand |
| b    | input     | 32    | Second operand |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | 32    | Low 32 bits of the addition |
| cout | output    | 1     | Carry out of bit 31 |

## Verification
The hardest case to reach from the ports is a carry that enters the low slice and travels through every propagate bit of all four slices. In that case each slice-boundary carry depends on the carry-in and on nothing generated locally. Random operands almost never give 32 consecutive propagate bits, so the stimulus builds them on purpose. It pairs a random `a` with its inverse as `b`, and it uses all-ones operands with a carry-in. Shorter runs that stop exactly at a slice edge are also driven. These show that each boundary carry comes from the expansion of the slice below it.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Widest slice the lookahead function accepts.
  localparam int unsigned LA_MAX_W = 16;

  // Carry into bit position idx of a slice (idx = gw gives the slice carry-out).
  // Expanded sum of products: each source (slice carry-in or a generate bit)
  // reaches idx only through an unbroken chain of propagate bits above it.
  function automatic logic la_carry(input logic [LA_MAX_W-1:0] g,
                                    input logic [LA_MAX_W-1:0] p,
                                    input logic                cin,
                                    input int                  idx);
    logic acc;
    acc = 1'b0;
    for (int j = 0; j <= LA_MAX_W; j++) begin
      logic term;
      if (j <= idx) begin
        if (j == 0) term = cin;
        else        term = g[j-1];
        for (int k = 0; k < LA_MAX_W; k++) begin
          if (k >= j && k < idx) term = term & p[k];
        end
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  // Sum bit from its propagate term and the carry entering it.
  function automatic logic sum_bit(input logic p, input logic c);
    return p ^ c;
  endfunction

endpackage

// File: rtl/cla_gp.sv
module cla_gp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = 8
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout
);
  logic [GW-1:0]       gen;
  logic [GW-1:0]       prop;
  logic [GW:0]         carry;
  logic [LA_MAX_W-1:0] gen_x;
  logic [LA_MAX_W-1:0] prop_x;

  cla_gp #(.W(GW)) u_gp (
    .a    (a),
    .b    (b),
    .gen  (gen),
    .prop (prop)
  );

  always_comb begin
    gen_x  = '0;
    prop_x = '0;
    gen_x[GW-1:0]  = gen;
    prop_x[GW-1:0] = prop;
  end

  // Every carry is taken from the slice inputs directly; none uses another.
  for (genvar i = 0; i <= GW; i++) begin : g_carry
    assign carry[i] = la_carry(gen_x, prop_x, cin, i);
  end

  for (genvar i = 0; i < GW; i++) begin : g_sum
    assign sum[i] = sum_bit(prop[i], carry[i]);
  end

  assign cout = carry[GW];
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned GROUP_W = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NGROUPS = WIDTH / GROUP_W;

  // Slice boundary carries: [0] is the external carry-in, [NGROUPS] the carry-out.
  logic [NGROUPS:0] grp_carry;

  assign grp_carry[0] = cin;

  for (genvar k = 0; k < NGROUPS; k++) begin : g_slice
    cla_group #(.GW(GROUP_W)) u_grp (
      .a    (a[k*GROUP_W +: GROUP_W]),
      .b    (b[k*GROUP_W +: GROUP_W]),
      .cin  (grp_carry[k]),
      .sum  (sum[k*GROUP_W +: GROUP_W]),
      .cout (grp_carry[k+1])
    );
  end

  assign cout = grp_carry[NGROUPS];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned NGROUPS = WIDTH / GROUP_W
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGROUPS:0] grp_carry
);
  logic [WIDTH:0] ref_total;
  logic           known;

  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign known     = !$isunknown({a, b, cin});

  always_comb begin
    if (known) begin
      p_sum_r1: assert (sum == ref_total[WIDTH-1:0]);
      p_cout_r2: assert (cout == ref_total[WIDTH]);
      if (a == '0 && b == '0)
        p_cin_entry_r4: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout);
      if (a == '1 && b == '0 && cin)
        p_full_wrap_r5: assert (sum == '0 && cout);
      if (b == ~a)
        p_all_prop_r6: assert (sum == {WIDTH{!cin}} && cout == cin);
    end
  end

  for (genvar k = 1; k < NGROUPS; k++) begin : g_bnd
    localparam logic [WIDTH-1:0] LOW_MASK = {WIDTH{1'b1}} >> (WIDTH - GROUP_W*k);
    logic [WIDTH:0] low_total;
    assign low_total = {1'b0, a & LOW_MASK} + {1'b0, b & LOW_MASK}
                     + {{WIDTH{1'b0}}, cin};
    always_comb begin
      if (known) p_slice_carry_r3: assert (grp_carry[k] == low_total[GROUP_W*k]);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_chk (
  .a         (a),
  .b         (b),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .grp_carry (grp_carry)
);

// File: tb/cla_adder_test.sv
module cla_adder_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  cla_adder uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  // {a, b, cin} directed vectors; expected results come from plain addition
  localparam int NV = 10;
  localparam logic [2*W:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0},  // R1 zero inputs
    {32'h0000_00FF, 32'h0000_0000, 1'b1},  // R3 into slice 1
    {32'h0000_FFFF, 32'h0000_0000, 1'b1},  // R3 into slice 2
    {32'h00FF_FFFF, 32'h0000_0000, 1'b1},  // R3 into slice 3
    {32'h0000_0080, 32'h0000_0080, 1'b0},  // R3 generate at slice top
    {32'h8000_0000, 32'h8000_0000, 1'b0},  // R2 carry out only
    {32'h1234_5678, 32'h9ABC_DEF0, 1'b1},  // R1 mixed
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},  // R1 long ripple
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},  // R2 all ones both
    {32'h00FF_00FF, 32'hFF00_FF00, 1'b1}   // R6 alternating slices
  };

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    n_cmp++;
    if (sum !== es || cout !== ec) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
               tag, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(posedge clk);
    #2;
  endtask

  task automatic run_ref(input string tag, input logic [W-1:0] va,
                         input logic [W-1:0] vb, input logic vc);
    logic [W:0] t;
    t = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    apply(va, vb, vc);
    check(tag, t[W-1:0], t[W]);
    apply(vb, va, vc);                     // R7 operands exchanged
    check({tag, "/R7"}, t[W-1:0], t[W]);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // Initial state with all inputs low (R1)
    apply('0, '0, 1'b0);
    check("R1 idle", '0, 1'b0);

    for (int i = 0; i < NV; i++)
      run_ref("R1/R2 table", VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);

    // Directed corner cases
    apply('0, '0, 1'b1);
    check("R4 cin enters bit0", 32'h0000_0001, 1'b0);
    apply('1, '0, 1'b1);
    check("R5 wrap all slices", '0, 1'b1);
    apply('0, '1, 1'b1);
    check("R5 wrap via b", '0, 1'b1);
    apply(32'h0000_00FF, '0, 1'b1);
    check("R3 slice0->1", 32'h0000_0100, 1'b0);
    apply(32'h00FF_FFFF, '0, 1'b1);
    check("R3 slice2->3", 32'h0100_0000, 1'b0);
    apply(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0);
    check("R6 inverse cin0", '1, 1'b0);
    apply(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1);
    check("R6 inverse cin1", '0, 1'b1);

    // Carry-chain stress: b = ~a gives a full propagate path
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] ra;
      logic         rc;
      ra = $urandom;
      rc = 1'($urandom);
      apply(ra, ~ra, rc);
      check("R6 random inverse", {W{!rc}}, rc);
    end

    // Random operands
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      run_ref("R1/R2 random", ra, rb, 1'($urandom));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule